// File: doc/BRIEF.md
# Half-Step Clock Divider

This block derives a slower clock waveform and a matching one-cycle enable pulse from a reference clock. It runs on a clock at twice the rate of the input clock being divided, so every reference cycle stands for half an input cycle. This lets the divider make half-integer ratios with a single clock edge. The divide factor comes from a small field in the low bits of a configuration word. A field value `f` divides the input rate by `(f+1)/2`, so the output rate is `2 x input / (f+1)`. Odd values give whole ratios and even values give half-integer ratios. A value of zero bypasses the divider and reproduces the input clock.

Software writes the configuration word and pulses a load strobe. The block holds that committed value and starts using it only when the output period in progress has finished. This means a change of ratio never produces a shortened or stretched pulse. The toggling waveform and the enable pulse are both registered outputs of the reference clock domain.

Top module: `halfstep_clk_div`

## Requirements
- R1: While `rst` is high, `div_out` and `tick` are low. In the first reference cycle after `rst` falls, a period begins: `tick` and `div_out` are both high, and the divide field is `DEF_FIELD`.
- R2: For a non-zero active field `f`, each output period lasts `f+1` reference cycles. This is `(f+1)/2` input cycles, giving an output rate of `2 x input / (f+1)`.
- R3: A field value of 0 bypasses division. The output repeats every 2 reference cycles, high for 1 and low for 1, which is the undivided input clock.
- R4: Within each period of length `P`, `div_out` is high for the first `ceil(P/2)` reference cycles and low for the rest. For even `P` the high and low times are equal. For odd `P` (half-integer ratios) the high time exceeds the low time by exactly one reference cycle, which is half an input cycle.
- R5: `tick` is high for exactly one reference cycle, the first cycle of every output period, and `div_out` is high in that cycle.
- R6: The field is `cfg_word[FIELD_W-1:0]`, captured on a cycle with `cfg_load` high. Bits of `cfg_word` above the field have no effect, and changes to `cfg_word` while `cfg_load` is low have no effect.
- R7: A newly loaded field takes effect only at the start of the period that follows the period in progress. The running period completes with its old length and duty.
- R8: Every field value up to the maximum `2^FIELD_W - 1` is accepted. The maximum gives a period of `2^FIELD_W` reference cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock, twice the rate of the input clock being divided |
| rst | input | 1 | Synchronous active-high reset |
| cfg_word | input | CFG_W | Configuration word; the divide field is in its low FIELD_W bits |
| cfg_load | input | 1 | Commit strobe for `cfg_word` |
| div_out | output | 1 | Divided clock waveform |
| tick | output | 1 | One-cycle pulse at the start of each output period |

## Verification
The bench builds the block with `FIELD_W = 5`, `CFG_W = 12` and `DEF_FIELD = 6`. This keeps the longest period at 32 reference cycles, so the full field range, including the maximum, can be measured in a short run. The reset default of 6 gives a half-integer ratio of 3.5, so the odd-period duty rule is covered straight out of reset. Seven unused upper configuration bits give room to drive random values there and show they are ignored. Random fields are mixed with directed cases for bypass, ratio 1, ratio 1.5, the maximum, a load in the middle of a period, and configuration changes without a load strobe.

// File: rtl/halfdiv_pkg.sv
package halfdiv_pkg;

    // Whether a field selects pass-through or real division.
    typedef enum logic [0:0] {
        SPAN_PASS = 1'b0,
        SPAN_DIV  = 1'b1
    } span_mode_e;

    // Shape of one output period in reference cycles.
    typedef struct packed {
        span_mode_e  mode;
        logic [31:0] period;
        logic [31:0] high;
    } span_t;

    // Period length: zero bypasses (same as ratio 1), otherwise field + 1.
    function automatic logic [31:0] period_of(input logic [31:0] field);
        return (field == 32'd0) ? 32'd2 : field + 32'd1;
    endfunction

    // High time: the larger half of the period.
    function automatic logic [31:0] high_of(input logic [31:0] period);
        return (period + 32'd1) >> 1;
    endfunction

    function automatic span_t span_of(input logic [31:0] field);
        span_t s;
        s.mode   = (field == 32'd0) ? SPAN_PASS : SPAN_DIV;
        s.period = period_of(field);
        s.high   = high_of(s.period);
        return s;
    endfunction

endpackage

// File: rtl/halfdiv_cfg_hold.sv
module halfdiv_cfg_hold #(
    parameter int FIELD_W   = 4,
    parameter int DEF_FIELD = 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [FIELD_W-1:0] field_in,
    input  logic               load,
    output logic [FIELD_W-1:0] field_held
);
    localparam logic [FIELD_W-1:0] RST_FIELD = FIELD_W'(DEF_FIELD);

    always_ff @(posedge clk) begin
        if (rst) begin
            field_held <= RST_FIELD;
        end else if (load) begin
            field_held <= field_in;
        end
    end
endmodule

// File: rtl/halfdiv_phase.sv
module halfdiv_phase
    import halfdiv_pkg::*;
#(
    parameter int FIELD_W   = 4,
    parameter int DEF_FIELD = 1,
    localparam int CNT_W    = FIELD_W + 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [FIELD_W-1:0] pending_field,
    output logic [FIELD_W-1:0] act_field,
    output logic [CNT_W-1:0]   nxt_cnt,
    output logic [CNT_W-1:0]   nxt_high,
    output logic               wrap
);
    localparam logic [31:0]        RST_PERIOD = period_of(32'(DEF_FIELD));
    localparam logic [CNT_W-1:0]   RST_LAST   = CNT_W'(RST_PERIOD - 32'd1);
    localparam logic [FIELD_W-1:0] RST_FIELD  = FIELD_W'(DEF_FIELD);

    logic [CNT_W-1:0]   cnt;
    logic [FIELD_W-1:0] field_d;
    span_t              cur_span;
    span_t              nxt_span;

    always_comb begin
        cur_span = span_of(32'(act_field));
        wrap     = (cnt == CNT_W'(cur_span.period - 32'd1));
        field_d  = wrap ? pending_field : act_field;
        nxt_span = span_of(32'(field_d));
        nxt_cnt  = wrap ? '0 : cnt + CNT_W'(1);
        nxt_high = CNT_W'(nxt_span.high);
    end

    // Reset parks the counter on the last cycle of a default period,
    // so the first cycle out of reset opens a fresh period.
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt       <= RST_LAST;
            act_field <= RST_FIELD;
        end else begin
            cnt       <= nxt_cnt;
            act_field <= field_d;
        end
    end
endmodule

// File: rtl/halfdiv_shaper.sv
module halfdiv_shaper #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wrap,
    input  logic [CNT_W-1:0] nxt_cnt,
    input  logic [CNT_W-1:0] nxt_high,
    output logic             wave,
    output logic             start
);
    // Outputs are computed from next state and registered: glitch-free
    // and aligned with the counter.
    always_ff @(posedge clk) begin
        if (rst) begin
            wave  <= 1'b0;
            start <= 1'b0;
        end else begin
            wave  <= (nxt_cnt < nxt_high);
            start <= wrap;
        end
    end
endmodule

// File: rtl/halfstep_clk_div.sv
module halfstep_clk_div #(
    parameter int FIELD_W   = 4,
    parameter int CFG_W     = 16,
    parameter int DEF_FIELD = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CFG_W-1:0] cfg_word,
    input  logic             cfg_load,
    output logic             div_out,
    output logic             tick
);
    localparam int CNT_W = FIELD_W + 1;

    logic [FIELD_W-1:0] field_held;
    logic [FIELD_W-1:0] act_field;
    logic [CNT_W-1:0]   nxt_cnt;
    logic [CNT_W-1:0]   nxt_high;
    logic               wrap;

    generate
        if (CFG_W > FIELD_W) begin : g_hi_bits
            logic unused_cfg_hi;
            assign unused_cfg_hi = ^cfg_word[CFG_W-1:FIELD_W];
        end
    endgenerate

    halfdiv_cfg_hold #(
        .FIELD_W   (FIELD_W),
        .DEF_FIELD (DEF_FIELD)
    ) u_hold (
        .clk        (clk),
        .rst        (rst),
        .field_in   (cfg_word[FIELD_W-1:0]),
        .load       (cfg_load),
        .field_held (field_held)
    );

    halfdiv_phase #(
        .FIELD_W   (FIELD_W),
        .DEF_FIELD (DEF_FIELD)
    ) u_phase (
        .clk           (clk),
        .rst           (rst),
        .pending_field (field_held),
        .act_field     (act_field),
        .nxt_cnt       (nxt_cnt),
        .nxt_high      (nxt_high),
        .wrap          (wrap)
    );

    halfdiv_shaper #(
        .CNT_W (CNT_W)
    ) u_shape (
        .clk      (clk),
        .rst      (rst),
        .wrap     (wrap),
        .nxt_cnt  (nxt_cnt),
        .nxt_high (nxt_high),
        .wave     (div_out),
        .start    (tick)
    );
endmodule

// File: rtl/halfstep_clk_div_chk.sv
module halfstep_clk_div_chk #(
    parameter int FIELD_W = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               div_out,
    input logic               tick,
    input logic [FIELD_W-1:0] act_field
);
    // R1: outputs quiet in the cycle after a reset edge
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!div_out && !tick));

    // R2: periods are at least two reference cycles, so ticks never abut
    a_r2_no_back_to_back: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

    // R5: the opening cycle of a period is a high cycle
    a_r5_tick_high: assert property (@(posedge clk) disable iff (rst)
        tick |-> div_out);

    // R4: the waveform only rises where a period starts
    a_r4_rise_at_start: assert property (@(posedge clk) disable iff (rst)
        $rose(div_out) |-> tick);

    // R7: the active ratio changes only on a period boundary
    a_r7_switch_at_boundary: assert property (@(posedge clk) disable iff (rst)
        !$stable(act_field) |-> tick);
endmodule

bind halfstep_clk_div halfstep_clk_div_chk #(
    .FIELD_W (FIELD_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .div_out   (div_out),
    .tick      (tick),
    .act_field (act_field)
);

// File: tb/halfstep_clk_div_tb.sv
`timescale 1ns/1ps
module halfstep_clk_div_tb;
    localparam int FIELD_W   = 5;
    localparam int CFG_W     = 12;
    localparam int DEF_FIELD = 6;
    localparam int FMAX      = (1 << FIELD_W) - 1;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [CFG_W-1:0] cfg_word = '0;
    logic             cfg_load = 1'b0;
    logic             div_out;
    logic             tick;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;

    always #10 clk = ~clk;

    halfstep_clk_div #(
        .FIELD_W   (FIELD_W),
        .CFG_W     (CFG_W),
        .DEF_FIELD (DEF_FIELD)
    ) u_dut (
        .clk      (clk),
        .rst      (rst),
        .cfg_word (cfg_word),
        .cfg_load (cfg_load),
        .div_out  (div_out),
        .tick     (tick)
    );

    function automatic int exp_period(input int f);
        return (f == 0) ? 2 : f + 1;
    endfunction

    function automatic int exp_high(input int p);
        return (p + 1) / 2;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_tick();
        int n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!tick && n < 200);
    endtask

    // Called at a negedge where tick is sampled high; ends at the next tick.
    task automatic run_period(input int f, input string req);
        int p   = exp_period(f);
        int h   = exp_high(p);
        int len = 0;
        int bad = -1;
        do begin
            if (div_out !== (len < h) && bad < 0) bad = len;
            @(negedge clk);
            len++;
        end while (!tick && len < 200);
        check(len == p, req, len, p);
        check(bad < 0, "R4 duty (first wrong cycle)", bad, -1);
    endtask

    task automatic load_field(input int f, input logic [CFG_W-1:0] upper);
        cfg_word = upper;
        cfg_word[FIELD_W-1:0] = FIELD_W'(f);
        cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
        wait_tick();
        wait_tick();
    endtask

    task automatic measure(input int f, input logic [CFG_W-1:0] upper, input string req);
        load_field(f, upper);
        run_period(f, req);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        // R1: quiet during reset
        repeat (3) @(negedge clk);
        check(div_out == 1'b0 && tick == 1'b0, "R1 reset quiet", int'({div_out, tick}), 0);
        rst = 1'b0;
        @(negedge clk);
        check(tick == 1'b1 && div_out == 1'b1, "R1 first cycle opens period", int'({div_out, tick}), 3);
        run_period(DEF_FIELD, "R1 default period");

        // Directed corners
        measure(0, '0, "R3 bypass period");
        measure(1, '0, "R2 ratio one");
        measure(2, '0, "R2 ratio one and a half");
        measure(FMAX, '0, "R8 maximum field");
        measure(3, {CFG_W{1'b1}}, "R6 upper bits ignored");

        // R7: load mid-period; running period keeps old length
        measure(9, '0, "R2 field 9");
        begin
            int len = 0;
            cfg_word = '0;
            cfg_word[FIELD_W-1:0] = FIELD_W'(4);
            cfg_load = 1'b1;
            do begin
                @(negedge clk);
                cfg_load = 1'b0;
                len++;
            end while (!tick && len < 200);
            check(len == exp_period(9), "R7 old period completes", len, exp_period(9));
            run_period(4, "R7 new period follows");
        end

        // R6: changes without load do nothing
        measure(11, '0, "R2 field 11");
        cfg_word = '0;
        cfg_word[FIELD_W-1:0] = FIELD_W'(2);
        run_period(11, "R6 no load keeps ratio");
        cfg_word = {CFG_W{1'b1}};
        run_period(11, "R6 no load keeps ratio again");

        // Random fields with random upper bits
        for (int i = 0; i < 24; i++) begin
            int f = int'($urandom_range(FMAX, 0));
            logic [CFG_W-1:0] up = CFG_W'($urandom);
            measure(f, up, (f == 0) ? "R3 random bypass" : "R2 random field");
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule